// File: doc/BRIEF.md
# FFSK Receive Frame Synchroniser and Checksum Checker

This block sits behind the bit-clock recovery of a fast-FSK receiver. It takes one recovered data bit per bit strobe and does three jobs on the raw stream: it hunts for a frame synchronisation word, it cuts the stream into bytes, and it keeps a running checksum verdict. Three sync matchers run side by side: a fixed word picked by a select input, the bitwise complement of that word, and a word loaded by the host. Each matcher only fires while its own arm bit is set. Any hit disarms all three, restarts byte framing so that the next bit is the first bit of a byte, and restarts the checksum checker.

Because the hardware cannot know how long a message is, the checker produces a pass/fail verdict at every byte boundary. The verdict tells whether all bits received since the checker last restarted form a valid message ending in a 16-bit checksum. Host software uses its knowledge of the message length to decide which verdict counts. Each completed byte is copied into a holding register, so the host has a full byte time to read it. The host can also restart the checker by hand at the next byte boundary.

Top module: `ffsk_rx_framer`

## Requirements
- R1: Lane 0 matches the fixed word, which is 1011010000110011 when `fixed_sel` is 1 and 1100010011010111 when it is 0. The window holds the most recent 16 received bits with the earliest one in the MSB. No lane matches until 16 bits have been received since reset.
- R2: Lane 1 matches the bitwise complement of the selected fixed word.
- R3: Lane 2 matches `prog_word`.
- R4: A lane fires (`sync_hit[i]` pulses high for one cycle) only while its arm bit `prime_q[i]` is set. A pulse on `arm_wr` loads `arm_wdata` into `prime_q` (bit 0 fixed, bit 1 complement, bit 2 programmable), so writing 0 disarms a lane.
- R5: Any hit clears all three arm bits. A hit wins over an `arm_wr` in the same cycle.
- R6: `byte_rdy` pulses on every 8th strobe counted from reset or from the last hit, whatever the data. The strobe that completes a sync word completes no byte and restarts the count.
- R7: At each `byte_rdy`, `rx_byte` takes the 8 bits just assembled, with the earliest bit in bit 7. It holds that value until the next `byte_rdy`.
- R8: At each `byte_rdy`, `crc_ok` takes the verdict over the n bits received since the checker restarted. The verdict is 1 only when two conditions hold. First, the first n-1 bits, with bit n-1 inverted, leave a zero remainder when divided by x^15+x^14+x^13+x^11+x^4+x^2+1. Second, the even parity of those first n-1 bits, taken as received, equals bit n.
- R9: A hit restarts the checker, so the first bit after the sync word is the first message bit.
- R10: A 0-to-1 change on `crc_ctl` restarts the checker at the first bit of the next byte.
- R11: After reset, `sync_hit`, `prime_q`, `byte_rdy`, `rx_byte` and `crc_ok` are all zero.
- R12: Every output is registered. A strobe's effect appears on the first clock edge of that strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received bit, sampled when `bit_stb` is high |
| fixed_sel | input | 1 | Selects which fixed sync word lanes 0 and 1 use |
| prog_word | input | 16 | Host-programmed sync word for lane 2 |
| arm_wr | input | 1 | Write strobe for the arm bits |
| arm_wdata | input | 3 | New arm bit values |
| crc_ctl | input | 1 | Manual checker restart request, acting on its rising edge |
| sync_hit | output | 3 | One-cycle hit pulse per lane |
| prime_q | output | 3 | Current arm bits |
| byte_rdy | output | 1 | One-cycle pulse when a byte is latched |
| rx_byte | output | 8 | Double-buffered received byte |
| crc_ok | output | 1 | Checksum verdict latched with `rx_byte` |

## Verification
Hit pulses, arm bits, `byte_rdy`, `rx_byte` and `crc_ok` are all due one clock edge after the cycle in which `bit_stb` or `arm_wr` is high. A `crc_ctl` rise is taken one edge later and only acts on a later byte-start strobe. The bench drives each stimulus on a falling edge, drops it on the next falling edge and samples right then, so it compares exactly the cycle in which the result is due against its own bit-level model. The checksum reference uses plain long division over the stored bits, and the sender builds its frames with an augmented division. Both are independent of the streaming form used in the design.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   localparam int unsigned LANE_N = 3;

   typedef enum logic [1:0] {
      LANE_FIX = 2'd0,
      LANE_CMP = 2'd1,
      LANE_PRG = 2'd2
   } lane_e;

   localparam logic [15:0] WORD_SEL1 = 16'b1011010000110011;
   localparam logic [15:0] WORD_SEL0 = 16'b1100010011010111;
   localparam logic [14:0] CRC_TAPS  = 15'h6815;

endpackage

// File: rtl/rxf_sync_match.sv
module rxf_sync_match
   import rxf_pkg::*;
#(
   parameter int unsigned        SYNC_W  = 16,
   parameter logic [SYNC_W-1:0]  WORD_HI = WORD_SEL1,
   parameter logic [SYNC_W-1:0]  WORD_LO = WORD_SEL0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic              fixed_sel,
   input  logic [SYNC_W-1:0] prog_word,
   input  logic              arm_wr,
   input  logic [LANE_N-1:0] arm_wdata,
   output logic [LANE_N-1:0] hit_now,
   output logic [LANE_N-1:0] sync_hit,
   output logic [LANE_N-1:0] prime_q
);

   localparam int unsigned FILL_W = $clog2(SYNC_W);
   localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(SYNC_W - 1);

   if (SYNC_W < 4) begin : g_bad_sync_w
      $error("rxf_sync_match: SYNC_W must be at least 4");
   end

   logic [SYNC_W-1:0] win_q;
   logic [SYNC_W-1:0] win_nx;
   logic [SYNC_W-1:0] base_word;
   logic [FILL_W-1:0] fill_q;
   logic              win_full;

   assign win_nx    = {win_q[SYNC_W-2:0], bit_in};
   assign base_word = fixed_sel ? WORD_HI : WORD_LO;
   assign win_full  = (fill_q == FILL_FULL);

   for (genvar i = 0; i < int'(LANE_N); i++) begin : g_lane
      logic [SYNC_W-1:0] target;
      if (i == int'(LANE_FIX)) begin : g_fix
         assign target = base_word;
      end else if (i == int'(LANE_CMP)) begin : g_cmp
         assign target = ~base_word;
      end else begin : g_prg
         assign target = prog_word;
      end
      assign hit_now[i] = bit_stb & win_full & prime_q[i] & (win_nx == target);

      // a lane can only report a hit if it was armed the cycle before
      assert_hit_needs_prime_R4: assert property (@(posedge clk) disable iff (!rst_n)
         sync_hit[i] |-> $past(prime_q[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (bit_stb) begin
         win_q <= win_nx;
         if (!win_full) fill_q <= fill_q + FILL_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_hit <= '0;
         prime_q  <= '0;
      end else begin
         sync_hit <= hit_now;
         if (|hit_now)    prime_q <= '0;
         else if (arm_wr) prime_q <= arm_wdata;
      end
   end

   assert_hit_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|sync_hit) |-> (prime_q == '0));

   assert_prime_only_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(arm_wr) && !(|sync_hit)) |-> $stable(prime_q));

endmodule

// File: rtl/rxf_crc_check.sv
module rxf_crc_check #(
   parameter int unsigned       CRC_W = 15,
   parameter logic [CRC_W-1:0]  TAPS  = rxf_pkg::CRC_TAPS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic bit_in,
   input  logic clear,
   input  logic at_start,
   input  logic crc_ctl,
   output logic verdict
);

   if (CRC_W < 2) begin : g_bad_crc_w
      $error("rxf_crc_check: CRC_W must be at least 2");
   end

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r, input logic b);
      logic fb;
      fb = r[CRC_W-1] ^ b;
      crc_step = {r[CRC_W-2:0], 1'b0} ^ (fb ? TAPS : '0);
   endfunction

   logic [CRC_W-1:0] rem_q;
   logic             par_q;
   logic             last_q;
   logic             have_q;
   logic             ctl_q;
   logic             pend_q;
   logic             ctl_rise;
   logic             restart;
   logic [CRC_W-1:0] chk_rem;

   assign ctl_rise = crc_ctl & ~ctl_q;
   assign restart  = bit_stb & at_start & pend_q & ~clear;
   assign chk_rem  = crc_step(rem_q, ~last_q);
   assign verdict  = have_q & (chk_rem == '0) & ((par_q ^ last_q) == bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ctl_q  <= crc_ctl;
         pend_q <= ctl_rise | (pend_q & ~restart & ~clear);
      end
   end

   // one bit of lag: the newest bit is held aside so the next-to-last
   // bit can be divided inverted when a verdict is taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         par_q  <= 1'b0;
         last_q <= 1'b0;
         have_q <= 1'b0;
      end else if (clear) begin
         rem_q  <= '0;
         par_q  <= 1'b0;
         last_q <= 1'b0;
         have_q <= 1'b0;
      end else if (restart) begin
         rem_q  <= '0;
         par_q  <= 1'b0;
         last_q <= bit_in;
         have_q <= 1'b1;
      end else if (bit_stb) begin
         if (have_q) begin
            rem_q <= crc_step(rem_q, last_q);
            par_q <= par_q ^ last_q;
         end
         last_q <= bit_in;
         have_q <= 1'b1;
      end
   end

   assert_restart_consumes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && !ctl_rise) |=> !pend_q);

   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !verdict);

endmodule

// File: rtl/rxf_byte_framer.sv
module rxf_byte_framer #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic              realign,
   input  logic              verdict,
   output logic              at_start,
   output logic              byte_rdy,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              crc_ok
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

   if (BYTE_W < 4) begin : g_bad_byte_w
      $error("rxf_byte_framer: BYTE_W must be at least 4");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] asm_q;
   logic              last_bit;

   assign at_start = (cnt_q == '0);
   assign last_bit = (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         asm_q    <= '0;
         byte_rdy <= 1'b0;
         rx_byte  <= '0;
         crc_ok   <= 1'b0;
      end else begin
         byte_rdy <= 1'b0;
         if (bit_stb) begin
            if (realign) begin
               cnt_q <= '0;
            end else begin
               asm_q <= {asm_q[BYTE_W-3:0], bit_in};
               if (last_bit) begin
                  cnt_q    <= '0;
                  rx_byte  <= {asm_q, bit_in};
                  crc_ok   <= verdict;
                  byte_rdy <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
         end
      end
   end

   assert_byte_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      byte_rdy |-> $past(bit_stb));

   assert_byte_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_rdy |-> $stable(rx_byte));

   assert_verdict_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_rdy |-> $stable(crc_ok));

endmodule

// File: rtl/ffsk_rx_framer.sv
module ffsk_rx_framer
   import rxf_pkg::*;
#(
   parameter int unsigned        SYNC_W   = 16,
   parameter int unsigned        BYTE_W   = 8,
   parameter int unsigned        CRC_W    = 15,
   parameter logic [CRC_W-1:0]   CRC_POLY = CRC_TAPS,
   parameter logic [SYNC_W-1:0]  WORD_HI  = WORD_SEL1,
   parameter logic [SYNC_W-1:0]  WORD_LO  = WORD_SEL0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_in,
   input  logic              fixed_sel,
   input  logic [SYNC_W-1:0] prog_word,
   input  logic              arm_wr,
   input  logic [LANE_N-1:0] arm_wdata,
   input  logic              crc_ctl,
   output logic [LANE_N-1:0] sync_hit,
   output logic [LANE_N-1:0] prime_q,
   output logic              byte_rdy,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              crc_ok
);

   if (CRC_W + 1 != SYNC_W) begin : g_bad_widths
      $error("ffsk_rx_framer: checksum field must be as wide as the sync word");
   end

   logic [LANE_N-1:0] hit_now;
   logic              any_hit;
   logic              at_start;
   logic              verdict;

   assign any_hit = |hit_now;

   rxf_sync_match #(
      .SYNC_W  (SYNC_W),
      .WORD_HI (WORD_HI),
      .WORD_LO (WORD_LO)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_stb   (bit_stb),
      .bit_in    (bit_in),
      .fixed_sel (fixed_sel),
      .prog_word (prog_word),
      .arm_wr    (arm_wr),
      .arm_wdata (arm_wdata),
      .hit_now   (hit_now),
      .sync_hit  (sync_hit),
      .prime_q   (prime_q)
   );

   rxf_crc_check #(
      .CRC_W (CRC_W),
      .TAPS  (CRC_POLY)
   ) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .bit_in   (bit_in),
      .clear    (any_hit),
      .at_start (at_start),
      .crc_ctl  (crc_ctl),
      .verdict  (verdict)
   );

   rxf_byte_framer #(
      .BYTE_W (BYTE_W)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_stb  (bit_stb),
      .bit_in   (bit_in),
      .realign  (any_hit),
      .verdict  (verdict),
      .at_start (at_start),
      .byte_rdy (byte_rdy),
      .rx_byte  (rx_byte),
      .crc_ok   (crc_ok)
   );

   assert_no_byte_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|sync_hit) |-> !byte_rdy);

   assert_outputs_follow_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (|sync_hit) |-> $past(bit_stb));

endmodule

// File: tb/ffsk_rx_framer_test.sv
`timescale 1ns/1ps
module ffsk_rx_framer_test;

   localparam logic [15:0] WA = 16'b1011010000110011;
   localparam logic [15:0] WB = 16'b1100010011010111;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bit_stb, bit_in, fixed_sel, arm_wr, crc_ctl;
   logic [15:0] prog_word;
   logic [2:0]  arm_wdata;
   logic [2:0]  sync_hit, prime_q;
   logic        byte_rdy, crc_ok;
   logic [7:0]  rx_byte;

   always #2.5 clk = ~clk;

   ffsk_rx_framer uut (
      .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_in(bit_in),
      .fixed_sel(fixed_sel), .prog_word(prog_word), .arm_wr(arm_wr),
      .arm_wdata(arm_wdata), .crc_ctl(crc_ctl), .sync_hit(sync_hit),
      .prime_q(prime_q), .byte_rdy(byte_rdy), .rx_byte(rx_byte), .crc_ok(crc_ok)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // bench model state
   logic [15:0] m_win = '0;
   int          m_fill = 0;
   logic [2:0]  m_prime = '0;
   int          m_cnt = 0;
   bit          m_pend = 0;
   bit          cbits [0:4095];
   int          m_n = 0;
   logic [7:0]  m_sr = '0;
   logic [7:0]  m_rx = '0;
   bit          m_ok = 0;
   bit          fbits [0:1023];
   int          flen = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R8 reference: long division of the first n-1 bits (bit n-1 inverted)
   function automatic bit ref_ok(int n);
      logic [15:0] r;
      bit p, v;
      r = '0;
      p = 0;
      if (n < 2) return 0;
      for (int i = 0; i < n - 1; i++) begin
         v = cbits[i];
         if (i == n - 2) v = ~v;
         p ^= cbits[i];
         r = {r[14:0], v};
         if (r[15]) r ^= 16'hE815;
      end
      return (r[14:0] == '0) && (p == cbits[n-1]);
   endfunction

   // sender side: data bytes, 15-bit remainder with last bit inverted, even parity
   task automatic make_frame(int m, bit flip);
      logic [15:0] r;
      logic [14:0] rem;
      bit p;
      flen = 0;
      for (int k = 0; k < m; k++) begin
         logic [7:0] d;
         d = 8'($urandom);
         for (int j = 7; j >= 0; j--) begin fbits[flen] = d[j]; flen++; end
      end
      r = '0;
      for (int i = 0; i < flen + 15; i++) begin
         r = {r[14:0], (i < flen) ? fbits[i] : 1'b0};
         if (r[15]) r ^= 16'hE815;
      end
      rem = r[14:0];
      rem[0] = ~rem[0];
      for (int j = 14; j >= 0; j--) begin fbits[flen] = rem[j]; flen++; end
      p = 0;
      for (int i = 0; i < flen; i++) p ^= fbits[i];
      fbits[flen] = p;
      flen++;
      if (flip) fbits[3] = ~fbits[3];
   endtask

   task automatic send_bit(bit b, bit doarm, logic [2:0] wd);
      logic [15:0] nw, base;
      logic [2:0]  eh;
      bit          full, ebr;
      @(negedge clk);
      bit_stb = 1'b1; bit_in = b; arm_wr = doarm; arm_wdata = wd;
      nw   = {m_win[14:0], b};
      base = fixed_sel ? WA : WB;
      full = (m_fill >= 15);
      eh[0] = m_prime[0] && full && (nw == base);
      eh[1] = m_prime[1] && full && (nw == ~base);
      eh[2] = m_prime[2] && full && (nw == prog_word);
      m_win = nw;
      if (m_fill < 16) m_fill++;
      ebr = 0;
      if (|eh) begin
         m_prime = '0; m_cnt = 0; m_n = 0; m_pend = 0;
      end else begin
         if (doarm) m_prime = wd;
         if (m_cnt == 0 && m_pend) begin m_n = 0; m_pend = 0; end
         if (m_n < 4096) begin cbits[m_n] = b; m_n++; end
         m_sr = {m_sr[6:0], b};
         m_cnt++;
         if (m_cnt == 8) begin
            m_cnt = 0; ebr = 1; m_rx = m_sr; m_ok = ref_ok(m_n);
         end
      end
      @(negedge clk);
      bit_stb = 1'b0; arm_wr = 1'b0;
      chk("R4 hit lanes", 32'(sync_hit), 32'(eh));
      chk("R5 arm bits", 32'(prime_q), 32'(m_prime));
      chk("R6 byte strobe", 32'(byte_rdy), 32'(ebr));
      chk("R7 held byte", 32'(rx_byte), 32'(m_rx));
      chk("R8 verdict", 32'(crc_ok), 32'(m_ok));
   endtask

   task automatic send_word(logic [15:0] w);
      for (int i = 15; i >= 0; i--) send_bit(w[i], 1'b0, 3'b000);
   endtask

   task automatic send_frame(int m, bit flip);
      make_frame(m, flip);
      for (int i = 0; i < flen; i++) send_bit(fbits[i], 1'b0, 3'b000);
      chk("R6 frame end byte", 32'(byte_rdy), 32'd1);
      chk("R8 frame verdict", 32'(crc_ok), flip ? 32'd0 : 32'd1);
   endtask

   task automatic arm(logic [2:0] wd);
      @(negedge clk);
      arm_wr = 1'b1; arm_wdata = wd;
      m_prime = wd;
      @(negedge clk);
      arm_wr = 1'b0;
      chk("R4 arm write", 32'(prime_q), 32'(wd));
   endtask

   task automatic ctl_pulse();
      @(negedge clk);
      crc_ctl = 1'b1;
      m_pend = 1;
      @(negedge clk);
      crc_ctl = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; bit_stb = 0; bit_in = 0; fixed_sel = 0; arm_wr = 0;
      arm_wdata = '0; crc_ctl = 0;
      void'($urandom(32'h5EED));
      prog_word = 16'($urandom);
      if (prog_word == WA || prog_word == ~WA || prog_word == WB || prog_word == ~WB)
         prog_word = 16'h3C5A;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset hits", 32'(sync_hit), 32'd0);
      chk("R11 reset arm", 32'(prime_q), 32'd0);
      chk("R11 reset strobe", 32'(byte_rdy), 32'd0);
      chk("R11 reset byte", 32'(rx_byte), 32'd0);
      chk("R11 reset verdict", 32'(crc_ok), 32'd0);

      for (int i = 0; i < 40; i++) send_bit(1'($urandom), 1'b0, 3'b000);

      // R1 fixed word, select high, then a good frame (R9 checker restarted by sync)
      fixed_sel = 1'b1;
      arm(3'b001);
      send_word(WA);
      chk("R1 fixed lane hit", 32'(sync_hit), 32'b001);
      chk("R5 disarmed after hit", 32'(prime_q), 32'd0);
      send_frame(3, 1'b0);
      chk("R9 verdict after sync", 32'(crc_ok), 32'd1);

      // R4 unarmed lane stays quiet; R2 complement lane
      fixed_sel = 1'b0;
      arm(3'b010);
      send_word(WB);
      chk("R4 unarmed fixed lane", 32'(sync_hit), 32'd0);
      send_word(~WB);
      chk("R2 complement hit", 32'(sync_hit), 32'b010);
      send_frame(2, 1'b0);

      // R3 programmable lane, then a corrupted frame
      arm(3'b100);
      send_word(prog_word);
      chk("R3 programmable hit", 32'(sync_hit), 32'b100);
      send_frame(4, 1'b0);
      arm(3'b100);
      send_word(prog_word);
      send_frame(2, 1'b1);

      // R4 writing zero disarms
      arm(3'b111);
      arm(3'b000);
      chk("R4 disarm by write", 32'(prime_q), 32'd0);

      // R5 hit beats a same-cycle arm write
      fixed_sel = 1'b1;
      arm(3'b001);
      for (int i = 15; i >= 1; i--) send_bit(WA[i], 1'b0, 3'b000);
      send_bit(WA[0], 1'b1, 3'b111);
      chk("R5 hit over write", 32'(prime_q), 32'd0);

      // R10 manual restart mid-byte takes effect at the next byte
      for (int i = 0; i < 3; i++) send_bit(1'($urandom), 1'b0, 3'b000);
      ctl_pulse();
      for (int i = 0; i < 5; i++) send_bit(1'($urandom), 1'b0, 3'b000);
      send_frame(3, 1'b0);
      chk("R10 manual restart verdict", 32'(crc_ok), 32'd1);

      // mixed random phase
      for (int it = 0; it < 1500; it++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 4) arm(3'($urandom));
         else if (r < 7) begin
            int s;
            s = int'($urandom % 3);
            if (s == 0) send_word(fixed_sel ? WA : WB);
            else if (s == 1) send_word(fixed_sel ? ~WA : ~WB);
            else send_word(prog_word);
         end
         else if (r < 9) ctl_pulse();
         else if (r < 10) fixed_sel = ~fixed_sel;
         else if (r < 12) @(negedge clk);
         else send_bit(1'($urandom), 1'b0, 3'b000);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R12 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule